// File: doc/BRIEF.md
# Mixed-Decay Current Chopper for One H-Bridge

This block regulates winding current in a single H-bridge. It runs at a fixed chopping rate. A free-running timebase splits each chopping period into five equal sub-periods. At every period boundary the bridge is put into charge. The external current comparator reports when the sensed current has reached its set point, and the bridge then moves to slow decay. When the last two sub-periods begin, the bridge switches to fast decay for the rest of the period. This gives a fixed 40 % fast-decay window.

A short charge interval for sensing is always applied, even when the current is already above the set point. The bridge leg gate enables are never switched straight from one drive pattern to another. Every change passes through a programmable all-off interval. A drive enable and a zero-current command both force the bridge off. Drive only starts again at a period boundary. The comparator, the current DAC and the sense resistor are outside the block. The comparator input arrives already synchronized to the clock.

Cycle numbering used below works as follows. Rising edges are counted from 0, starting at the first edge that samples `rst_n` high. The interval after edge n is position (n+1) mod 100. An input "at position k" is the value sampled by the edge that ends position k. The defaults are: sub-period 20 cycles, five sub-periods (period 100), two fast sub-periods (boundary at position 60), dead time D = 15 cycles, minimum sensing charge S = 8 cycles.

Top module: `chop_ctrl`

## Requirements
- R1: The chopping period is 100 clock cycles, made of five sub-periods of 20 cycles. Fast decay is requested from the edge ending position 60 and lasts up to the period boundary, so its gates are off for positions 61..75.
- R2: When enabled at position 0, each period first drives charge. Gates are all off in positions 1..D and show the charge pattern from position D+1.
- R3: When the comparator is high at position L (D+S <= L <= 43), charge ends after position L. Gates are off for positions L+1..L+D and show slow decay (`{hi_p,lo_p,hi_n,lo_n}` = 0101) from L+D+1 to position 60.
- R4: Fast decay drives the diagonal opposite to charge, from position 76 to the end of the period. If the comparator never fires, charge lasts to position 60.
- R5: Charge lasts at least S cycles before slow decay, even when the comparator is high from the start of the period. Slow decay then begins only after the comparator is seen at position D+S or later.
- R6: Every change of drive pattern passes through exactly D cycles with all four gates low. The high and low gate of one leg are never on together.
- R7: If enable rises after position 0, the gates stay off for the rest of that period. Drive starts at the next period boundary.
- R8: When `enable` is low or `cur_zero` is high at position k, all gates are low from position k+1 on.
- R9: Forward (`dir`=0) charge is 1001 and forward fast decay is 0110. Reverse swaps these two patterns. `dir` is sampled only at position 0, so later changes take effect at the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Drive enable; low forces the bridge off |
| dir | input | 1 | Current direction, 0 forward, 1 reverse |
| cur_zero | input | 1 | Commanded current is zero; forces the bridge off |
| at_target | input | 1 | Synchronized comparator: sensed current has reached set point |
| hi_p | output | 1 | Gate enable, high-side switch of the first leg |
| lo_p | output | 1 | Gate enable, low-side switch of the first leg |
| hi_n | output | 1 | Gate enable, high-side switch of the second leg |
| lo_n | output | 1 | Gate enable, low-side switch of the second leg |

## Verification
An input sampled at position k reaches the mode register at the same edge. The gates show the effect in position k+1 when the change is to off. When the change is to a drive pattern, the gates show it D cycles later, in position k+D+1.

The bench keeps its own position counter from the first edge with reset released. It drives inputs and samples the gates at falling edges. For every position 1..99 of every period it compares the gates against a function of that position, the comparator trip point, the direction latched at position 0, and the cycle of any disable. Position 0 is not compared.

Trip points and disable cycles are drawn at random within limits. These limits keep each dead interval clear of the next forced change.

// File: rtl/chop_pkg.sv
// Package: shared drive command type and gate decode for the chopper.
// Assumes gate vector order {hi_p, lo_p, hi_n, lo_n}.
package chop_pkg;

    typedef enum logic [1:0] {
        DM_OFF    = 2'd0,
        DM_CHARGE = 2'd1,
        DM_SLOW   = 2'd2,
        DM_FAST   = 2'd3
    } drive_mode_e;

    typedef struct packed {
        logic        rev;
        drive_mode_e mode;
    } drive_cmd_t;

    // Map a drive command to the four gate enables.
    function automatic logic [3:0] gates_of(input drive_cmd_t c);
        logic [3:0] g;
        unique case (c.mode)
            DM_CHARGE: g = c.rev ? 4'b0110 : 4'b1001;
            DM_FAST:   g = c.rev ? 4'b1001 : 4'b0110;
            DM_SLOW:   g = 4'b0101;
            default:   g = 4'b0000;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/chop_timebase.sv
// Module: chop_timebase
// Divides the master clock into sub-period ticks and groups them into
// chopping periods. Flags the first cycle of each period and the
// fast-decay window (the last FAST_TICKS sub-periods).
// Assumes TICK_DIV >= 2 and 1 <= FAST_TICKS < TICKS_PER_PERIOD.
module chop_timebase #(
    parameter int TICK_DIV         = 20,
    parameter int TICKS_PER_PERIOD = 5,
    parameter int FAST_TICKS       = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic period_start,
    output logic fast_zone
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int SW = (TICKS_PER_PERIOD > 1) ? $clog2(TICKS_PER_PERIOD) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(TICK_DIV - 1);
    localparam logic [SW-1:0] SUB_LAST  = SW'(TICKS_PER_PERIOD - 1);
    localparam logic [SW-1:0] SUB_FAST  = SW'(TICKS_PER_PERIOD - FAST_TICKS);

    logic [TW-1:0] tick_q;
    logic [SW-1:0] sub_q;

    // Advance the tick divider and the sub-period index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            sub_q  <= '0;
        end else if (tick_q == TICK_LAST) begin
            tick_q <= '0;
            sub_q  <= (sub_q == SUB_LAST) ? '0 : sub_q + SW'(1);
        end else begin
            tick_q <= tick_q + TW'(1);
        end
    end

    assign period_start = (tick_q == '0) && (sub_q == '0);
    assign fast_zone    = (sub_q >= SUB_FAST);

    p_period_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q == TICK_LAST && sub_q == SUB_LAST) |=> period_start);
    p_sub_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_q <= SUB_LAST) && (tick_q <= TICK_LAST));
    p_fast_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_zone && !period_start) |=> (!fast_zone || $past(tick_q) == TICK_LAST));

endmodule

// File: rtl/chop_mode_fsm.sv
// Module: chop_mode_fsm
// Chooses the requested bridge mode every cycle: charge at period start,
// slow decay once the comparator fires after the minimum sensing charge,
// fast decay inside the fast window, off when disabled. Direction is
// latched at period start. Assumes at_target is already synchronous.
module chop_mode_fsm
    import chop_pkg::*;
#(
    parameter int DEAD_CYC  = 15,
    parameter int SENSE_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       period_start,
    input  logic       fast_zone,
    input  logic       enable,
    input  logic       dir,
    input  logic       cur_zero,
    input  logic       at_target,
    output drive_cmd_t cmd
);
    localparam int AGE_LIM = DEAD_CYC + SENSE_CYC - 1;
    localparam int AW      = $clog2(AGE_LIM + 1) + 1;

    drive_cmd_t    cmd_q, cmd_d;
    logic [AW-1:0] age_q;
    logic          sense_done;

    assign sense_done = (age_q >= AW'(AGE_LIM));

    // Next requested mode from timebase, enables and comparator.
    always_comb begin
        cmd_d = cmd_q;
        if (!enable || cur_zero) begin
            cmd_d.mode = DM_OFF;
        end else if (period_start) begin
            cmd_d.mode = DM_CHARGE;
            cmd_d.rev  = dir;
        end else if (cmd_q.mode == DM_OFF) begin
            cmd_d.mode = DM_OFF;
        end else if (fast_zone) begin
            cmd_d.mode = DM_FAST;
        end else if (cmd_q.mode == DM_CHARGE && sense_done && at_target) begin
            cmd_d.mode = DM_SLOW;
        end
    end

    // Register the requested mode.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '{rev: 1'b0, mode: DM_OFF};
        else        cmd_q <= cmd_d;
    end

    // Count cycles spent in charge since the period began.
    always_ff @(posedge clk) begin
        if (!rst_n || period_start)
            age_q <= '0;
        else if (cmd_q.mode == DM_CHARGE && !sense_done)
            age_q <= age_q + AW'(1);
    end

    assign cmd = cmd_q;

    p_start_charge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && enable && !cur_zero) |=> (cmd_q.mode == DM_CHARGE));
    p_fast_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_zone && !period_start && enable && !cur_zero && cmd_q.mode != DM_OFF)
        |=> (cmd_q.mode == DM_FAST));
    p_sense_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q.mode == DM_CHARGE && !sense_done) |=> (cmd_q.mode != DM_SLOW));
    p_no_late_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q.mode == DM_OFF && !period_start) |=> (cmd_q.mode == DM_OFF));
    p_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || cur_zero) |=> (cmd_q.mode == DM_OFF));
    p_dir_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> $stable(cmd_q.rev));

endmodule

// File: rtl/chop_deadband.sv
// Module: chop_deadband
// Applies the requested drive command to the gates, holding all four
// gates low for DEAD_CYC cycles whenever the request differs from the
// applied command. Assumes DEAD_CYC >= 1.
module chop_deadband
    import chop_pkg::*;
#(
    parameter int DEAD_CYC = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  drive_cmd_t req,
    output logic [3:0] gates
);
    localparam int CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
    localparam logic [CW-1:0] DT_LAST = CW'(DEAD_CYC - 1);

    drive_cmd_t    applied_q;
    logic [CW-1:0] dt_q;
    logic          busy;

    assign busy = (req != applied_q);

    // Count out the dead interval, then adopt the requested command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            applied_q <= '{rev: 1'b0, mode: DM_OFF};
            dt_q      <= '0;
        end else if (busy) begin
            if (dt_q == DT_LAST) begin
                applied_q <= req;
                dt_q      <= '0;
            end else begin
                dt_q <= dt_q + CW'(1);
            end
        end else begin
            dt_q <= '0;
        end
    end

    assign gates = busy ? 4'b0000 : gates_of(applied_q);

    p_dead_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gates != 4'b0000 && $past(gates) != 4'b0000) |-> (gates == $past(gates)));
    p_leg_safe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(gates[3] && gates[2]) && !(gates[1] && gates[0]));

endmodule

// File: rtl/chop_ctrl.sv
// Module: chop_ctrl (top)
// Fixed-frequency mixed-decay current chopper for one H-bridge:
// timebase, mode selection and dead-time insertion. Assumes the
// comparator input is synchronous to clk.
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int TICK_DIV         = 20,
    parameter int TICKS_PER_PERIOD = 5,
    parameter int FAST_TICKS       = 2,
    parameter int DEAD_CYC         = 15,
    parameter int SENSE_CYC        = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic dir,
    input  logic cur_zero,
    input  logic at_target,
    output logic hi_p,
    output logic lo_p,
    output logic hi_n,
    output logic lo_n
);
    logic       period_start;
    logic       fast_zone;
    drive_cmd_t req;
    logic [3:0] gates;

    chop_timebase #(
        .TICK_DIV        (TICK_DIV),
        .TICKS_PER_PERIOD(TICKS_PER_PERIOD),
        .FAST_TICKS      (FAST_TICKS)
    ) i_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_start(period_start),
        .fast_zone   (fast_zone)
    );

    chop_mode_fsm #(
        .DEAD_CYC (DEAD_CYC),
        .SENSE_CYC(SENSE_CYC)
    ) i_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_start(period_start),
        .fast_zone   (fast_zone),
        .enable      (enable),
        .dir         (dir),
        .cur_zero    (cur_zero),
        .at_target   (at_target),
        .cmd         (req)
    );

    chop_deadband #(
        .DEAD_CYC(DEAD_CYC)
    ) i_dead (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (req),
        .gates(gates)
    );

    assign {hi_p, lo_p, hi_n, lo_n} = gates;

endmodule

// File: tb/test_chop_ctrl.sv
// Bench for chop_ctrl: directed and seeded random periods, every
// position 1..99 compared against an expected-gate function.
module test_chop_ctrl;
    localparam int PER   = 100;
    localparam int DEAD  = 15;
    localparam int SENSE = 8;
    localparam int FZ    = 60;
    localparam int TRIP_MAX = FZ - DEAD - 2;
    localparam int NONE  = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, dir = 1'b0, cur_zero = 1'b0, at_target = 1'b0;
    logic hi_p, lo_p, hi_n, lo_n;
    int   checks = 0;
    int   errors = 0;

    always #10 clk = ~clk;

    chop_ctrl i_chop_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .dir(dir),
        .cur_zero(cur_zero), .at_target(at_target),
        .hi_p(hi_p), .lo_p(lo_p), .hi_n(hi_n), .lo_n(lo_n)
    );

    function automatic logic [3:0] chg(bit rev);
        return rev ? 4'b0110 : 4'b1001;
    endfunction

    function automatic logic [3:0] fst(bit rev);
        return rev ? 4'b1001 : 4'b0110;
    endfunction

    // Charge end position: comparator trip (not before D+S) or the fast boundary.
    function automatic int charge_end(int trip);
        if (trip > TRIP_MAX) return FZ;
        return (trip < DEAD + SENSE) ? DEAD + SENSE : trip;
    endfunction

    function automatic logic [3:0] exp_gates(int p, int trip, bit rev, bit started, int kill);
        int ce;
        if (!started || p > kill) return 4'b0000;
        ce = charge_end(trip);
        if (p <= DEAD) return 4'b0000;
        if (p <= ce) return chg(rev);
        if (ce < FZ) begin
            if (p <= ce + DEAD) return 4'b0000;
            if (p <= FZ) return 4'b0101;
        end
        if (p <= FZ + DEAD) return 4'b0000;
        return fst(rev);
    endfunction

    function automatic string tag_of(int p, int trip, bit rev, bit started, int kill);
        int ce;
        if (!started) return "R7";
        if (p > kill) return "R8";
        if (rev) return "R9";
        ce = charge_end(trip);
        if (p <= DEAD) return "R2";
        if (p <= ce) return (trip < DEAD + SENSE) ? "R5" : "R2";
        if (ce < FZ && p <= ce + DEAD) return "R6";
        if (ce < FZ && p <= FZ) return "R3";
        if (p <= FZ + DEAD) return "R1";
        return "R4";
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp, int p);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pos %0d gates act=%b exp=%b", tag, p, act, exp);
        end
    endtask

    // One period: en_at = position enable rises, kill = position of drop,
    // kill_zero selects cur_zero instead of enable, flip = dir change position.
    task automatic run_period(int trip, bit rev, int en_at, int kill, bit kill_zero, int flip);
        bit started;
        started = (en_at == 0);
        for (int p = 0; p < PER; p++) begin
            if (p != 0)
                check(tag_of(p, trip, rev, started, kill), {hi_p, lo_p, hi_n, lo_n},
                      exp_gates(p, trip, rev, started, kill), p);
            at_target = (p >= trip);
            dir       = (p >= flip) ? ~rev : rev;
            enable    = (p >= en_at) && !(!kill_zero && p >= kill);
            cur_zero  = kill_zero && (p >= kill);
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        enable = 1'b1;
        repeat (5) @(negedge clk);
        check("R8", {hi_p, lo_p, hi_n, lo_n}, 4'b0000, 0);
        rst_n = 1'b1;
        // Directed corner cases.
        run_period(NONE, 1'b0, 0, NONE, 1'b0, NONE);   // R1 R4 no trip
        run_period(1, 1'b0, 0, NONE, 1'b0, NONE);      // R5 above target
        run_period(30, 1'b0, 0, NONE, 1'b0, NONE);     // R3 slow decay
        run_period(TRIP_MAX, 1'b1, 0, NONE, 1'b0, NONE); // R9 reverse
        run_period(30, 1'b0, 0, 50, 1'b0, NONE);       // R8 enable low
        run_period(NONE, 1'b0, 30, NONE, 1'b0, NONE);  // R7 late enable
        run_period(25, 1'b0, 0, NONE, 1'b0, NONE);     // R7 drive resumes
        run_period(NONE, 1'b1, 0, 40, 1'b1, NONE);     // R8 zero current
        run_period(30, 1'b0, 0, NONE, 1'b0, 20);       // R9 flip latched
        run_period(30, 1'b1, 0, NONE, 1'b0, NONE);     // R9 new direction
        // Seeded random periods.
        for (int n = 0; n < 24; n++) begin
            int  trip, kill, en_at, flip;
            bit  rev, kz;
            trip  = ($urandom % 4 == 0) ? NONE : 1 + int'($urandom % TRIP_MAX);
            rev   = 1'($urandom);
            kill  = ($urandom % 4 == 0) ? 20 + int'($urandom % 61) : NONE;
            kz    = 1'($urandom);
            en_at = ($urandom % 8 == 0) ? 1 + int'($urandom % 98) : 0;
            flip  = ($urandom % 3 == 0) ? 1 + int'($urandom % 98) : NONE;
            run_period(trip, rev, en_at, kill, kz, flip);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule